// File: doc/BRIEF.md
# Program Counter Branch and Call Sequencer

This block owns the byte-addressed 21-bit program counter of a small processor whose instructions are 16 bits wide. It takes one instruction word per instruction cycle, qualified by a valid strobe, and advances the counter by one word (2 bytes) for every ordinary word. Two control-flow instructions are executed here. One is a relative branch that is taken only when the zero flag is set. The other is a two-word absolute subroutine call that pushes its return address onto an internal hardware return stack.

The branch adds a sign-extended, word-scaled 8-bit offset to the address of the next word. When the branch is taken, the sequencer raises a one-cycle flush, and the word presented in that cycle is discarded. The call takes the low 8 bits of its 20-bit word target from its first word and the high 12 bits from a second word. It pushes the address that follows both words and loads the target with bit 0 cleared. When its context bit is set, the call also copies the working, status and bank-select register values into shadow copies. The return stack holds a fixed number of entries, and an overflow flag stays set once a push has been refused.

Top module: `pcseq_top`

## Requirements
- R1: While `rstN` is low, `pcOut`, `tosOut`, all three shadow outputs, `flush`, `callErr` and `stackOverflow` are all 0.
- R2: A word accepted with `instrValid`=1 that is neither a branch nor a call first word adds 2 to `pcOut`. A cycle with `instrValid`=0 leaves `pcOut` unchanged, whatever the word and flag values are.
- R3: A word whose upper byte is 0xE0 is a branch whose lower byte is a signed offset n. When `zeroFlag`=1, the next `pcOut` is (pc + 2 + 2n) modulo 2^21.
- R4: The same branch word with `zeroFlag`=0 adds 2 to `pcOut` and does not raise `flush`.
- R5: After a taken branch, `flush` is 1 for exactly one cycle. The word presented in that cycle is discarded, and `pcOut` does not change even if that word is a branch or a call word.
- R6: A call first word has bits [15:9] equal to 1110110, bit 8 equal to the context bit s, and bits [7:0] equal to k[7:0]. It adds 2 to `pcOut` and pushes nothing. A following second word with bits [15:12] equal to 1111 carries k[19:8] in bits [11:0]. It sets `pcOut` to {k, 0}, and `tosOut` becomes the address of the first word plus 4.
- R7: When s=1, the second word's cycle copies `wIn`, `statusIn` and `bsrIn` into `wShadow`, `statusShadow` and `bsrShadow`. When s=0, the shadow outputs do not change.
- R8: If the word after a call first word has bits [15:12] not equal to 1111, nothing is pushed and `tosOut` and the shadows do not change. `pcOut` moves 2 past that word, and `callErr` is 1 for exactly one cycle.
- R9: The return stack holds 31 entries, and `tosOut` shows the most recent one. A push when the stack is full stores nothing, leaves `tosOut` unchanged, still loads the call target into `pcOut`, and sets `stackOverflow`, which then stays 1 until reset.
- R10: While a call waits for its second word, cycles with `instrValid`=0 leave `pcOut` and `tosOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | `instrWord` holds a word to consume this cycle |
| instrWord | input | 16 | Fetched instruction word |
| zeroFlag | input | 1 | Current zero flag |
| wIn | input | 8 | Current working register |
| statusIn | input | 8 | Current status register |
| bsrIn | input | 8 | Current bank-select register |
| pcOut | output | 21 | Program counter (byte address) |
| tosOut | output | 21 | Top return-stack entry, 0 when empty |
| wShadow | output | 8 | Saved working register |
| statusShadow | output | 8 | Saved status register |
| bsrShadow | output | 8 | Saved bank-select register |
| flush | output | 1 | Discard the word fetched this cycle |
| callErr | output | 1 | One-cycle pulse for a malformed call |
| stackOverflow | output | 1 | Sticky: a push was refused on a full stack |

## Verification
A stale sequencer state, such as a call still waiting for its second word or a flush left pending, changes how the very next accepted word is treated. `pcOut` therefore shows the error one edge later, either as a missing +2 or as a jump to a target built from unrelated bits. A wrong held low literal or a wrong stack pointer does not appear until the call completes, and then shows in the target address or in `tosOut` on that same edge. A pointer fault near the full boundary appears only on the 31st or 32nd nested call. For that reason the stack is filled to capacity and pushed once more.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int PC_W     = 21;
  localparam int LIT_LO_W = 8;
  localparam int LIT_HI_W = 12;
  localparam int OPB_W    = 8;

  localparam logic [7:0] OP_BRZ     = 8'hE0;
  localparam logic [6:0] OP_CALL_LO = 7'b1110110;
  localparam logic [3:0] OP_CALL_HI = 4'hF;

  typedef struct packed {
    logic advance;  // pc += 2
    logic branch;   // pc += 2 + 2n
    logic latchLo;  // capture low target literal
    logic call;     // push and load target
    logic saveCtx;  // copy context into shadows
  } seqStrobe_t;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [OPB_W-1:0] opByte,
  input  logic             zeroFlag,
  output seqStrobe_t       strobe,
  output logic             flush,
  output logic             callErr
);
  typedef enum logic [1:0] {ST_RUN, ST_CALL2, ST_FLUSH} seqState_t;

  seqState_t state, stateNxt;
  logic ctxHeld, ctxNxt, errSet;
  logic isBranch, isCallLo, isCallHi;

  assign isBranch = (opByte == OP_BRZ);
  assign isCallLo = (opByte[7:1] == OP_CALL_LO);
  assign isCallHi = (opByte[7:4] == OP_CALL_HI);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    ctxNxt   = ctxHeld;
    errSet   = 1'b0;
    unique case (state)
      ST_RUN: if (instrValid) begin
        if (isBranch && zeroFlag) begin
          strobe.branch = 1'b1;
          stateNxt      = ST_FLUSH;
        end else if (isCallLo) begin
          strobe.advance = 1'b1;
          strobe.latchLo = 1'b1;
          ctxNxt         = opByte[0];
          stateNxt       = ST_CALL2;
        end else begin
          strobe.advance = 1'b1;
        end
      end
      ST_CALL2: if (instrValid) begin
        stateNxt = ST_RUN;
        if (isCallHi) begin
          strobe.call    = 1'b1;
          strobe.saveCtx = ctxHeld;
        end else begin
          strobe.advance = 1'b1;
          errSet         = 1'b1;
        end
      end
      ST_FLUSH: stateNxt = ST_RUN;
      default:  stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      ctxHeld <= 1'b0;
      callErr <= 1'b0;
    end else begin
      state   <= stateNxt;
      ctxHeld <= ctxNxt;
      callErr <= errSet;
    end
  end

  assign flush = (state == ST_FLUSH);

  // R5
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !flush);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    callErr |=> !callErr);

  // R2
  pc_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.advance, strobe.branch, strobe.call}));

  // R5
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (strobe == '0));
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int DEPTH  = 31,
  parameter int DATA_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] tos,
  output logic              overflow
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr;
  logic              full;

  assign full = (ptr == PTR_W'(DEPTH));

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !full && ptr == PTR_W'(i)) mem[i] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      overflow <= 1'b0;
    end else if (push) begin
      if (full) overflow <= 1'b1;
      else      ptr      <= ptr + PTR_W'(1);
    end
  end

  always_comb begin
    tos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr == PTR_W'(i + 1)) tos = mem[i];
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(DEPTH));

  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |=> ($stable(tos) && overflow));
endmodule

// File: rtl/pcseq_dp.sv
module pcseq_dp
  import pcseq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [LIT_HI_W-1:0] lit,
  input  logic [REG_W-1:0]    wIn,
  input  logic [REG_W-1:0]    statusIn,
  input  logic [REG_W-1:0]    bsrIn,
  output logic [PC_W-1:0]     pc,
  output logic                pushEn,
  output logic [PC_W-1:0]     pushData,
  output logic [REG_W-1:0]    wShadow,
  output logic [REG_W-1:0]    statusShadow,
  output logic [REG_W-1:0]    bsrShadow
);
  localparam int EXT_W = PC_W - LIT_LO_W - 1;

  logic [LIT_LO_W-1:0] kLo;
  logic [PC_W-1:0]     pcInc, offset, target;

  assign pcInc    = pc + PC_W'(2);
  assign offset   = {{EXT_W{lit[LIT_LO_W-1]}}, lit[LIT_LO_W-1:0], 1'b0};
  assign target   = {lit, kLo, 1'b0};
  assign pushEn   = strobe.call;
  assign pushData = pcInc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc  <= '0;
      kLo <= '0;
    end else begin
      if (strobe.latchLo) kLo <= lit[LIT_LO_W-1:0];
      if (strobe.call)         pc <= target;
      else if (strobe.branch)  pc <= pcInc + offset;
      else if (strobe.advance) pc <= pcInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wShadow      <= '0;
      statusShadow <= '0;
      bsrShadow    <= '0;
    end else if (strobe.saveCtx) begin
      wShadow      <= wIn;
      statusShadow <= statusIn;
      bsrShadow    <= bsrIn;
    end
  end

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.advance || strobe.branch || strobe.call) |=> $stable(pc));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveCtx |=> $stable({wShadow, statusShadow, bsrShadow}));

  // R6
  call_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.call |=> (pc[0] == 1'b0));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int STACK_DEPTH = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [15:0]      instrWord,
  input  logic             zeroFlag,
  input  logic [REG_W-1:0] wIn,
  input  logic [REG_W-1:0] statusIn,
  input  logic [REG_W-1:0] bsrIn,
  output logic [20:0]      pcOut,
  output logic [20:0]      tosOut,
  output logic [REG_W-1:0] wShadow,
  output logic [REG_W-1:0] statusShadow,
  output logic [REG_W-1:0] bsrShadow,
  output logic             flush,
  output logic             callErr,
  output logic             stackOverflow
);
  seqStrobe_t      strobe;
  logic            pushEn;
  logic [PC_W-1:0] pushData;

  pcseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .opByte     (instrWord[15:8]),
    .zeroFlag   (zeroFlag),
    .strobe     (strobe),
    .flush      (flush),
    .callErr    (callErr)
  );

  pcseq_dp #(.REG_W(REG_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lit          (instrWord[11:0]),
    .wIn          (wIn),
    .statusIn     (statusIn),
    .bsrIn        (bsrIn),
    .pc           (pcOut),
    .pushEn       (pushEn),
    .pushData     (pushData),
    .wShadow      (wShadow),
    .statusShadow (statusShadow),
    .bsrShadow    (bsrShadow)
  );

  pcseq_stack #(.DEPTH(STACK_DEPTH), .DATA_W(PC_W)) u_stack (
    .clk      (clk),
    .rstN     (rstN),
    .push     (pushEn),
    .pushData (pushData),
    .tos      (tosOut),
    .overflow (stackOverflow)
  );

  // R8
  err_no_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(callErr) |-> $stable(tosOut));
endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        zeroFlag = 1'b0;
  logic [7:0]  wIn = '0, statusIn = '0, bsrIn = '0;
  logic [20:0] pcOut, tosOut;
  logic [7:0]  wShadow, statusShadow, bsrShadow;
  logic        flush, callErr, stackOverflow;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcseq_top u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .zeroFlag(zeroFlag), .wIn(wIn), .statusIn(statusIn), .bsrIn(bsrIn),
    .pcOut(pcOut), .tosOut(tosOut), .wShadow(wShadow),
    .statusShadow(statusShadow), .bsrShadow(bsrShadow), .flush(flush),
    .callErr(callErr), .stackOverflow(stackOverflow)
  );

  typedef struct packed {
    logic        v;
    logic [15:0] word;
    logic        z;
    logic [7:0]  w, st, bs;
    logic [20:0] expPc, expTos;
    logic        expFl;
    logic [23:0] expSh;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 16'h1234, 1'b0, 8'h11, 8'h22, 8'h33, 21'h000002, 21'h0, 1'b0, 24'h0, 8'd2},  // R2
    '{1'b0, 16'hE005, 1'b1, 8'h11, 8'h22, 8'h33, 21'h000002, 21'h0, 1'b0, 24'h0, 8'd2},  // R2
    '{1'b1, 16'hE005, 1'b0, 8'h11, 8'h22, 8'h33, 21'h000004, 21'h0, 1'b0, 24'h0, 8'd4},  // R4
    '{1'b1, 16'hE005, 1'b1, 8'h11, 8'h22, 8'h33, 21'h000010, 21'h0, 1'b1, 24'h0, 8'd3},  // R3
    '{1'b1, 16'hE002, 1'b1, 8'h11, 8'h22, 8'h33, 21'h000010, 21'h0, 1'b0, 24'h0, 8'd5},  // R5
    '{1'b1, 16'hE0FE, 1'b1, 8'h11, 8'h22, 8'h33, 21'h00000E, 21'h0, 1'b1, 24'h0, 8'd3},  // R3
    '{1'b1, 16'hEC01, 1'b0, 8'h11, 8'h22, 8'h33, 21'h00000E, 21'h0, 1'b0, 24'h0, 8'd5},  // R5
    '{1'b1, 16'hEC34, 1'b0, 8'h11, 8'h22, 8'h33, 21'h000010, 21'h0, 1'b0, 24'h0, 8'd6},  // R6
    '{1'b1, 16'hF12A, 1'b0, 8'hAA, 8'hBB, 8'hCC, 21'h025468, 21'h12, 1'b0, 24'h0, 8'd7}, // R6 R7
    '{1'b1, 16'hED01, 1'b0, 8'h11, 8'h22, 8'h33, 21'h02546A, 21'h12, 1'b0, 24'h0, 8'd6}, // R6
    '{1'b1, 16'hF000, 1'b0, 8'h5A, 8'h1C, 8'h07, 21'h000002, 21'h02546C, 1'b0, 24'h5A1C07, 8'd7}, // R7
    '{1'b1, 16'hE080, 1'b1, 8'h11, 8'h22, 8'h33, 21'h1FFF04, 21'h02546C, 1'b1, 24'h5A1C07, 8'd3}, // R3 wrap
    '{1'b1, 16'h0000, 1'b0, 8'h11, 8'h22, 8'h33, 21'h1FFF04, 21'h02546C, 1'b0, 24'h5A1C07, 8'd5}  // R5
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [15:0] wd, bit z, logic [7:0] w, logic [7:0] st, logic [7:0] bs);
    instrValid = v; instrWord = wd; zeroFlag = z;
    wIn = w; statusIn = st; bsrIn = bs;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; instrValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pc", 32'(pcOut), 0);
    check("R1 tos", 32'(tosOut), 0);
    check("R1 shadows", 32'({wShadow, statusShadow, bsrShadow}), 0);
    check("R1 flags", 32'({flush, callErr, stackOverflow}), 0);
    rstN = 1'b1;
  endtask

  initial begin
    logic [20:0] prevPc, lastTos;
    @(negedge clk);
    doReset();

    for (int i = 0; i < 13; i++) begin
      step(VEC[i].v, VEC[i].word, VEC[i].z, VEC[i].w, VEC[i].st, VEC[i].bs);
      check($sformatf("R%0d row%0d pc", VEC[i].req, i), 32'(pcOut), 32'(VEC[i].expPc));
      check($sformatf("R%0d row%0d tos", VEC[i].req, i), 32'(tosOut), 32'(VEC[i].expTos));
      check($sformatf("R%0d row%0d flush", VEC[i].req, i), 32'(flush), 32'(VEC[i].expFl));
      check($sformatf("R%0d row%0d shadow", VEC[i].req, i),
            32'({wShadow, statusShadow, bsrShadow}), 32'(VEC[i].expSh));
      check($sformatf("R%0d row%0d callErr", VEC[i].req, i), 32'(callErr), 0);
    end

    // R8: malformed call second word
    step(1, 16'hEC00, 0, 8'h99, 8'h98, 8'h97);
    check("R8 first word pc", 32'(pcOut), 32'h1FFF06);
    step(1, 16'h1234, 0, 8'h99, 8'h98, 8'h97);
    check("R8 err pulse", 32'(callErr), 1);
    check("R8 pc past word", 32'(pcOut), 32'h1FFF08);
    check("R8 no push", 32'(tosOut), 32'h02546C);
    check("R8 shadows kept", 32'({wShadow, statusShadow, bsrShadow}), 32'h5A1C07);
    step(0, 16'h0000, 0, 8'h0, 8'h0, 8'h0);
    check("R8 err one cycle", 32'(callErr), 0);

    // R10: wait between the two call words
    step(1, 16'hEC07, 0, 8'h0, 8'h0, 8'h0);
    check("R10 first word pc", 32'(pcOut), 32'h1FFF0A);
    step(0, 16'hF000, 0, 8'h0, 8'h0, 8'h0);
    check("R10 wait pc", 32'(pcOut), 32'h1FFF0A);
    check("R10 wait tos", 32'(tosOut), 32'h02546C);
    step(1, 16'hF000, 0, 8'h0, 8'h0, 8'h0);
    check("R10 target pc", 32'(pcOut), 32'h00000E);
    check("R10 return addr", 32'(tosOut), 32'h1FFF0C);

    // R1 again mid-run, then R9 stack capacity
    doReset();
    prevPc = '0;
    for (int i = 0; i < 31; i++) begin
      step(1, {8'hEC, 8'(i + 1)}, 0, 8'h0, 8'h0, 8'h0);
      step(1, 16'hF000, 0, 8'h0, 8'h0, 8'h0);
      check($sformatf("R9 push%0d tos", i), 32'(tosOut), 32'(prevPc + 21'd4));
      check($sformatf("R9 push%0d pc", i), 32'(pcOut), 32'((i + 1) * 2));
      prevPc = 21'((i + 1) * 2);
    end
    lastTos = tosOut;
    check("R9 no overflow at capacity", 32'(stackOverflow), 0);
    step(1, 16'hEC40, 0, 8'h0, 8'h0, 8'h0);
    step(1, 16'hF000, 0, 8'h0, 8'h0, 8'h0);
    check("R9 overflow set", 32'(stackOverflow), 1);
    check("R9 tos kept", 32'(tosOut), 32'(lastTos));
    check("R9 target still loaded", 32'(pcOut), 32'h80);
    step(1, 16'h1234, 0, 8'h0, 8'h0, 8'h0);
    check("R9 overflow sticky", 32'(stackOverflow), 1);
    check("R2 after overflow", 32'(pcOut), 32'h82);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule